// File: doc/BRIEF.md
# Audio Sample Level Monitor

This block observes a stream of unsigned audio samples, each marked by a one-cycle valid strobe, and drives two indicator outputs. The center indicator shows that the most recent sample sits exactly on the mid-scale code. The no-signal level is half the converter reference, so this indicator is used to trim the input bias until a switching output would run at 50% duty.

The clip indicator warns that the signal is too hot. Any valid sample that comes close to either rail loads a hold counter. The indicator stays lit while that counter is nonzero. The counter counts down on a separate tick-enable input, so the visible pulse length is set independently of the sample rate.

Top module: `audio_level_monitor`

## Requirements
- R1: After reset is asserted (rst_n low), `center_o` and `clip_o` are both 0.
- R2: One clock after a valid sample equal to 511 (`{1'b0, 9'h1FF}` at 10 bits), `center_o` is 1.
- R3: One clock after a valid sample with any other value, `center_o` is 0. This includes the neighbours 510 and 512.
- R4: While `smp_valid` is 0, `center_o` keeps its value, whatever `smp_data` carries.
- R5: A valid sample is a clip event exactly when its value is above 1000 or below 22. The values 1000 and 22 themselves are not events, and 1001 and 21 are.
- R6: One clock after a clip event, `clip_o` is 1 and the hold count is 254.
- R7: The hold count drops by one on each clock with `tick_en` high and stays unchanged otherwise. `clip_o` is 1 exactly while the count is nonzero. After a load with no further events, `clip_o` stays high through 253 ticks and falls on the clock of the 254th tick.
- R8: A clip event reloads the count to 254 whenever it occurs. If a tick comes on the same clock, the reload wins over the decrement.
- R9: A sample presented with `smp_valid` low creates no clip event and does not change `center_o`, even when its value is near a rail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe that marks `smp_data` as a new sample |
| smp_data | input | 10 | Unsigned audio sample |
| tick_en | input | 1 | Hold counter decrement enable |
| center_o | output | 1 | Most recent sample is mid-scale |
| clip_o | output | 1 | Stretched near-rail indicator |

## Verification
Directed samples step across both clip thresholds (21/22, 1000/1001) and across the mid code (510/511/512). These patterns show whether each comparison is strict, inclusive or off by one.

A clip load followed by exactly 253 and then 254 ticks measures the stretch length. A clip event coinciding with a tick shows whether the reload wins over the decrement. Rail values presented with the strobe low show whether the block gates on the strobe.

Random streams mix sample values biased toward the rails and the mid code with random strobe and tick densities. These streams exercise the interaction between reloads, countdown and center hold.

// File: rtl/alm_pkg.sv
package alm_pkg;

    // Result of classifying one sample
    typedef struct packed {
        logic at_mid;
        logic near_rail;
    } alm_flags_t;

endpackage

// File: rtl/alm_classify.sv
module alm_classify #(
    parameter int SAMPLE_W = 10,
    parameter int MID_CODE = 511,
    parameter int RAIL_HI  = 1000,
    parameter int RAIL_LO  = 22
) (
    input  logic [SAMPLE_W-1:0] smp,
    output alm_pkg::alm_flags_t flags
);
    localparam logic [SAMPLE_W-1:0] MID_V = SAMPLE_W'(MID_CODE);
    localparam logic [SAMPLE_W-1:0] HI_V  = SAMPLE_W'(RAIL_HI);
    localparam logic [SAMPLE_W-1:0] LO_V  = SAMPLE_W'(RAIL_LO);

    always_comb begin
        flags.at_mid    = (smp == MID_V);
        flags.near_rail = (smp > HI_V) || (smp < LO_V);
    end
endmodule

// File: rtl/alm_hold.sv
module alm_hold #(
    parameter int HOLD_LOAD = 254,
    localparam int HOLD_W = $clog2(HOLD_LOAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick_en,
    output logic active
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = HOLD_W'(HOLD_LOAD);
        end else if (tick_en && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/audio_level_monitor.sv
module audio_level_monitor #(
    parameter int SAMPLE_W  = 10,
    parameter int RAIL_HI   = 1000,
    parameter int RAIL_LO   = 22,
    parameter int HOLD_LOAD = 254,
    localparam int MID_CODE = (1 << (SAMPLE_W - 1)) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                tick_en,
    output logic                center_o,
    output logic                clip_o
);
    typedef struct packed {
        logic center;
    } mon_st_t;

    alm_pkg::alm_flags_t flags;
    mon_st_t st_d, st_q;
    logic clip_evt;

    alm_classify #(
        .SAMPLE_W(SAMPLE_W), .MID_CODE(MID_CODE),
        .RAIL_HI(RAIL_HI),   .RAIL_LO(RAIL_LO)
    ) i_classify (
        .smp(smp_data), .flags(flags)
    );

    always_comb begin
        st_d     = st_q;
        clip_evt = smp_valid && flags.near_rail;
        if (smp_valid) st_d.center = flags.at_mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    alm_hold #(.HOLD_LOAD(HOLD_LOAD)) i_hold (
        .clk(clk), .rst_n(rst_n), .load(clip_evt),
        .tick_en(tick_en), .active(clip_o)
    );

    assign center_o = st_q.center;
endmodule

// File: rtl/alm_checker.sv
module alm_checker #(
    parameter int SAMPLE_W = 10,
    parameter int RAIL_HI  = 1000,
    parameter int RAIL_LO  = 22
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                tick_en,
    input logic                center_o,
    input logic                clip_o
);
    localparam logic [SAMPLE_W-1:0] MID_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] HI_V  = SAMPLE_W'(RAIL_HI);
    localparam logic [SAMPLE_W-1:0] LO_V  = SAMPLE_W'(RAIL_LO);

    logic evt;
    assign evt = smp_valid && ((smp_data > HI_V) || (smp_data < LO_V));

    // R2
    center_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_data == MID_V |=> center_o);
    // R3
    center_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && smp_data != MID_V |=> !center_o);
    // R4
    center_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(center_o));
    // R6
    clip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> clip_o);
    // R7
    clip_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !evt |=> $stable(clip_o));
    // R7
    clip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clip_o) |-> $past(tick_en) && !$past(evt));
    // R9
    no_evt_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid && !clip_o |=> !clip_o);
endmodule

bind audio_level_monitor alm_checker #(
    .SAMPLE_W(SAMPLE_W), .RAIL_HI(RAIL_HI), .RAIL_LO(RAIL_LO)
) i_alm_checker (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .tick_en(tick_en), .center_o(center_o), .clip_o(clip_o)
);

// File: tb/test_audio_level_monitor.sv
module test_audio_level_monitor;
    logic clk = 0, rst_n = 0, smp_valid = 0, tick_en = 0;
    logic [9:0] smp_data = '0;
    logic center_o, clip_o;
    int n_run = 0, n_fail = 0;
    bit m_center = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    audio_level_monitor i_audio_level_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .tick_en(tick_en), .center_o(center_o), .clip_o(clip_o)
    );

    function automatic bit f_evt(bit v, int d);
        return v && (d > 1000 || d < 22);
    endfunction

    function automatic int f_cnt(int c, bit v, int d, bit t);
        if (f_evt(v, d)) return 254;
        if (t && c > 0) return c - 1;
        return c;
    endfunction

    task automatic check(string tag, bit act, bit exp, string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // drive at negedge, clock, update model, compare at next negedge
    task automatic step(bit v, int d, bit t, string tag);
        smp_valid = v; smp_data = 10'(d); tick_en = t;
        @(posedge clk);
        if (v) m_center = (d == 511);
        m_cnt = f_cnt(m_cnt, v, d, t);
        @(negedge clk);
        check(tag, center_o, m_center, "center_o");
        check(tag, clip_o, m_cnt != 0, "clip_o");
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1
        check("R1", center_o, 0, "center_o");
        check("R1", clip_o, 0, "clip_o");
        rst_n = 1;
        // R2 / R3
        step(1, 511, 0, "R2");
        step(1, 510, 0, "R3");
        step(1, 511, 0, "R2");
        step(1, 512, 0, "R3");
        step(1, 511, 0, "R2");
        // R4 / R9: invalid data does not move center or clip
        step(0, 100, 0, "R4");
        step(0, 1023, 0, "R9");
        step(0, 0, 1, "R9");
        // R5 boundaries
        step(1, 1000, 0, "R5");
        step(1, 22, 0, "R5");
        step(1, 1001, 0, "R5");
        // R7: 253 ticks keep high, 254th clears
        for (int i = 0; i < 253; i++) step(0, 0, 1, "R7");
        check("R7", clip_o, 1, "clip_o after 253 ticks");
        step(0, 0, 1, "R7");
        check("R7", clip_o, 0, "clip_o after 254 ticks");
        // R6 low rail
        step(1, 21, 0, "R6");
        for (int i = 0; i < 200; i++) step(0, 0, 1, "R7");
        // R8 event with tick -> full reload
        step(1, 1023, 1, "R8");
        for (int i = 0; i < 253; i++) step(0, 0, 1, "R8");
        check("R8", clip_o, 1, "clip_o after reload+253 ticks");
        step(0, 0, 1, "R8");
        // random
        for (int i = 0; i < 20000; i++) begin
            int r = $urandom_range(0, 9);
            int d;
            if (r < 2)      d = $urandom_range(0, 30);
            else if (r < 4) d = $urandom_range(995, 1023);
            else if (r < 6) d = $urandom_range(509, 513);
            else            d = $urandom_range(0, 1023);
            step($urandom_range(0, 3) == 0, d, $urandom_range(0, 1) == 1, "R5");
        end
        // R1 again mid-activity
        step(1, 0, 0, "R6");
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        check("R1", center_o, 0, "center_o");
        check("R1", clip_o, 0, "clip_o");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule